// File: doc/BRIEF.md
# Randomized Montgomery-Ladder Round Engine over GF(2^m)

This block computes the x-only scalar multiple k·P of a point on a binary-field elliptic curve y² + xy = x³ + ax² + b. It returns the result in projective (X, Z) form. The caller supplies the affine x coordinate of the base point, the curve constant b and an m-bit scalar, then pulses `start`. The engine runs one ladder round per scalar bit, from the most significant bit down. Each round does a point addition and a point doubling together. It produces `done` together with the projective coordinates of register R0, which the caller converts to affine form as X·Z⁻¹.

Every round follows one fixed stage schedule, whatever the scalar bit. Each stage launches a pool of three bit-serial field multipliers in lockstep. Field additions (XOR) are folded into the operand selection and the write-back. When `mask_en` is set at start, every round first takes a fresh random field element through a valid/ready handshake. Two extra closing stages then scale all four output coordinates by that element. This changes the projective representation of both ladder points in every round and leaves the affine points unchanged.

Top module: `ladder_round_engine`

## Requirements
- R1: While and after reset, until the next start: `busy`, `done` and `rnd_ready` are 0, and `res_x` and `res_z` are 0.
- R2: `done` is high for exactly one cycle per operation. In that cycle (`res_x`, `res_z`) holds R0. In unprotected mode, R0 equals the ladder result from the round formulas: sum Z = (X0·Z1 + X1·Z0)², sum X = x·Z + (X0·Z1)·(X1·Z0); double X = Xd⁴ + b·Zd⁴, double Z = Xd²·Zd².
- R3: The ladder starts from R0 = (1, 0) and R1 = (x, 1) and takes scalar bits from bit m-1 down to bit 0. So k = 0 gives Z = 0, k = 1 gives affine x, and k = 2 gives affine x² + b/x².
- R4: The doubled point is R0 when the round's scalar bit is 0 and R1 when it is 1. For bit 0 the sum goes to R1 and the double to R0. For bit 1 the sum goes to R0 and the double to R1.
- R5: Protected and unprotected runs of the same scalar and point give the same affine result.
- R6: In protected mode, `rnd_ready` is raised once at the start of every round and exactly m handshakes occur per operation. In unprotected mode, `rnd_ready` is never raised.
- R7: A random value of zero is replaced by one. An all-zero random stream therefore gives exactly the unprotected projective result.
- R8: A round takes 13·(m+2)+2 cycles when protected and 11·(m+2)+2 when unprotected, with `rnd_valid` held high. `done` is high in the cycle that follows m·(round length) clock edges after the edge that accepted `start`.
- R9: Each stage starts three m-cycle field multipliers on the same cycle, and all of them finish on the same cycle.
- R10: A `start` pulse while `busy` is high is ignored. The running operation's result and latency are unchanged.
- R11: In a protected round, the two closing stages multiply sum X, sum Z, double X and double Z by that round's random value. Random values are used in handshake order, the first one for the bit m-1 round.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (accepted only when idle) |
| mask_en | input | 1 | Per-round coordinate re-randomization enable, sampled with start |
| scalar | input | M | Scalar k |
| base_x | input | M | Affine x of the base point |
| curve_b | input | M | Curve constant b |
| rnd_valid | input | 1 | Random value available |
| rnd_value | input | M | Per-round random field element |
| rnd_ready | output | 1 | Engine takes a random value this cycle |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| res_x | output | M | Projective X of R0 |
| res_z | output | M | Projective Z of R0 |

## Verification
The bench builds the engine with m = 8 and the reduction polynomial x⁸ + x⁴ + x³ + x + 1. This makes a protected multiplication about a thousand cycles long, so many scalar bit patterns, both modes and several random streams fit in one run. At this field size the bench can find inverses by exhaustive search. It can also predict the exact per-round projective coordinates, including the random scaling, and compare affine results across modes. The small width also lets exact latency checks cover every round of the operation.

// File: rtl/ladder_pkg.sv
package ladder_pkg;

    localparam int unsigned NUM_MUL    = 3;
    localparam int unsigned STG_PLAIN  = 11;
    localparam int unsigned STG_MASKED = 13;
    localparam int unsigned STG_W      = 4;
    localparam int unsigned NUM_TMP    = 13;
    localparam int unsigned NUM_SRC    = 24;
    localparam logic [3:0]  FIN_STAGE  = 4'd10;

    // Operand / destination names. The first NUM_TMP entries index the
    // temporary register file directly.
    typedef enum logic [4:0] {
        S_T1, S_T2, S_T3, S_T4, S_S1, S_S2, S_S3, S_S4, S_S5,
        S_XA, S_ZA, S_XN, S_ZN,
        S_X1, S_Z1, S_X2, S_Z2, S_XD, S_ZD, S_XB, S_BC, S_RND,
        S_TSUM, S_ZERO
    } src_e;

    typedef struct packed {
        logic en;
        src_e a;
        src_e b;
        src_e dst;
    } mul_op_t;

    typedef enum logic [2:0] {
        ST_IDLE, ST_RBEGIN, ST_LAUNCH, ST_WAIT, ST_COMMIT, ST_DONE
    } fsm_e;

    function automatic mul_op_t mk_op(input src_e a, input src_e b, input src_e d);
        mul_op_t op;
        op.en  = 1'b1;
        op.a   = a;
        op.b   = b;
        op.dst = d;
        return op;
    endfunction

    // Unified round schedule: addition and doubling operations interleave
    // on the same stage sequence; stages 11 and 12 re-randomize outputs.
    function automatic mul_op_t sched_op(input logic [3:0] stg, input int slot);
        mul_op_t op;
        op.en  = 1'b0;
        op.a   = S_ZERO;
        op.b   = S_ZERO;
        op.dst = S_T1;
        if (slot == 0) begin
            case (stg)
                4'd0:  op = mk_op(S_X1,   S_Z2,   S_T1);
                4'd1:  op = mk_op(S_XD,   S_XD,   S_S1);
                4'd2:  op = mk_op(S_X2,   S_Z1,   S_T2);
                4'd3:  op = mk_op(S_ZD,   S_ZD,   S_S2);
                4'd4:  op = mk_op(S_TSUM, S_TSUM, S_ZA);
                4'd5:  op = mk_op(S_S1,   S_S2,   S_ZN);
                4'd6:  op = mk_op(S_T1,   S_T2,   S_T3);
                4'd7:  op = mk_op(S_S1,   S_S1,   S_S3);
                4'd8:  op = mk_op(S_XB,   S_ZA,   S_T4);
                4'd9:  op = mk_op(S_S2,   S_S2,   S_S4);
                4'd10: op = mk_op(S_BC,   S_S4,   S_S5);
                4'd11: op = mk_op(S_XA,   S_RND,  S_XA);
                4'd12: op = mk_op(S_ZN,   S_RND,  S_ZN);
                default: ;
            endcase
        end else if (slot == 1) begin
            if (stg == 4'd11) op = mk_op(S_ZA, S_RND, S_ZA);
        end else begin
            if (stg == 4'd11) op = mk_op(S_XN, S_RND, S_XN);
        end
        return op;
    endfunction

    function automatic logic [3:0] stage_count(input logic masked);
        return masked ? 4'(STG_MASKED) : 4'(STG_PLAIN);
    endfunction

endpackage

// File: rtl/gf_serial_mul.sv
module gf_serial_mul #(
    parameter int unsigned M        = 233,
    parameter logic [M-1:0] POLY_LOW = M'((75'd1 << 74) | 75'd1)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [M-1:0] a,
    input  logic [M-1:0] b,
    output logic         done,
    output logic [M-1:0] p
);
    localparam int unsigned CW = $clog2(M + 1);

    logic [M-1:0]  acc, a_sh, b_q, step;
    logic [CW-1:0] cnt;
    logic          busy;

    // MSB-first shift-and-add with interleaved reduction
    always_comb begin
        step = {acc[M-2:0], 1'b0} ^ (acc[M-1] ? POLY_LOW : '0);
        if (a_sh[M-1]) step = step ^ b_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc  <= '0;
            a_sh <= '0;
            b_q  <= '0;
            cnt  <= '0;
            busy <= 1'b0;
        end else if (start) begin
            acc  <= '0;
            a_sh <= a;
            b_q  <= b;
            cnt  <= CW'(M);
            busy <= 1'b1;
        end else if (busy) begin
            if (cnt != '0) begin
                acc  <= step;
                a_sh <= a_sh << 1;
                cnt  <= cnt - 1'b1;
            end else begin
                busy <= 1'b0;
            end
        end
    end

    assign done = busy && (cnt == '0);
    assign p    = acc;

    p_done_single_r9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    p_start_clears_r9: assert property (@(posedge clk) disable iff (rst)
        start |=> !done);

endmodule

// File: rtl/ladder_datapath.sv
module ladder_datapath
    import ladder_pkg::*;
#(
    parameter int unsigned M        = 233,
    parameter logic [M-1:0] POLY_LOW = M'((75'd1 << 74) | 75'd1)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         init,
    input  logic [M-1:0] base_x,
    input  logic [M-1:0] curve_b,
    input  logic         launch,
    input  logic [3:0]   stg,
    input  logic         wb,
    input  logic         rnd_cap,
    input  logic [M-1:0] rnd_value,
    input  logic         commit,
    input  logic         kbit,
    output logic         mul_done,
    output logic [M-1:0] r0_x,
    output logic [M-1:0] r0_z
);
    logic [M-1:0] r0x, r0z, r1x, r1z, xb, bc, rq;
    logic [M-1:0] tmp  [NUM_TMP];
    logic [M-1:0] srcv [NUM_SRC];
    logic [M-1:0] mres [NUM_MUL];
    logic [NUM_MUL-1:0] mdone;
    mul_op_t ops [NUM_MUL];

    always_comb begin
        for (int u = 0; u < NUM_MUL; u++) ops[u] = sched_op(stg, u);
    end

    // Operand network; the adders sit here (TSUM) and in write-back
    always_comb begin
        for (int i = 0; i < NUM_SRC; i++) srcv[i] = '0;
        for (int i = 0; i < NUM_TMP; i++) srcv[i] = tmp[i];
        srcv[S_X1]   = r0x;
        srcv[S_Z1]   = r0z;
        srcv[S_X2]   = r1x;
        srcv[S_Z2]   = r1z;
        srcv[S_XD]   = kbit ? r1x : r0x;
        srcv[S_ZD]   = kbit ? r1z : r0z;
        srcv[S_XB]   = xb;
        srcv[S_BC]   = bc;
        srcv[S_RND]  = rq;
        srcv[S_TSUM] = tmp[S_T1] ^ tmp[S_T2];
    end

    for (genvar u = 0; u < NUM_MUL; u++) begin : g_unit
        gf_serial_mul #(.M(M), .POLY_LOW(POLY_LOW)) mul_i (
            .clk   (clk),
            .rst   (rst),
            .start (launch),
            .a     (srcv[ops[u].a]),
            .b     (srcv[ops[u].b]),
            .done  (mdone[u]),
            .p     (mres[u])
        );
    end

    assign mul_done = mdone[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            r0x <= '0; r0z <= '0; r1x <= '0; r1z <= '0;
            xb  <= '0; bc  <= '0; rq  <= '0;
            for (int i = 0; i < NUM_TMP; i++) tmp[i] <= '0;
        end else begin
            if (init) begin
                r0x <= M'(1);
                r0z <= '0;
                r1x <= base_x;
                r1z <= M'(1);
                xb  <= base_x;
                bc  <= curve_b;
            end
            if (rnd_cap) rq <= (rnd_value == '0) ? M'(1) : rnd_value;
            if (wb) begin
                for (int u = 0; u < NUM_MUL; u++)
                    if (ops[u].en) tmp[4'(ops[u].dst)] <= mres[u];
                if (stg == FIN_STAGE) begin
                    tmp[S_XA] <= tmp[S_T4] ^ tmp[S_T3];
                    tmp[S_XN] <= tmp[S_S3] ^ mres[0];
                end
            end
            if (commit) begin
                if (kbit) begin
                    r0x <= tmp[S_XA]; r0z <= tmp[S_ZA];
                    r1x <= tmp[S_XN]; r1z <= tmp[S_ZN];
                end else begin
                    r1x <= tmp[S_XA]; r1z <= tmp[S_ZA];
                    r0x <= tmp[S_XN]; r0z <= tmp[S_ZN];
                end
            end
        end
    end

    assign r0_x = r0x;
    assign r0_z = r0z;

    p_units_lockstep_r9: assert property (@(posedge clk) disable iff (rst)
        (mdone == '0) || (mdone == '1));
    p_route_bit0_r4: assert property (@(posedge clk) disable iff (rst)
        (commit && !kbit) |=> (r1x == $past(tmp[S_XA])) && (r0z == $past(tmp[S_ZN])));
    p_route_bit1_r4: assert property (@(posedge clk) disable iff (rst)
        (commit && kbit) |=> (r0x == $past(tmp[S_XA])) && (r1z == $past(tmp[S_ZN])));
    p_rnd_nonzero_r7: assert property (@(posedge clk) disable iff (rst)
        rnd_cap |=> (rq != '0));
    p_ladder_init_r3: assert property (@(posedge clk) disable iff (rst)
        init |=> (r0x == M'(1)) && (r0z == '0) && (r1z == M'(1)));

endmodule

// File: rtl/ladder_round_engine.sv
module ladder_round_engine
    import ladder_pkg::*;
#(
    parameter int unsigned M        = 233,
    parameter logic [M-1:0] POLY_LOW = M'((75'd1 << 74) | 75'd1)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic         mask_en,
    input  logic [M-1:0] scalar,
    input  logic [M-1:0] base_x,
    input  logic [M-1:0] curve_b,
    input  logic         rnd_valid,
    input  logic [M-1:0] rnd_value,
    output logic         rnd_ready,
    output logic         busy,
    output logic         done,
    output logic [M-1:0] res_x,
    output logic [M-1:0] res_z
);
    localparam int unsigned NBITS = M;
    localparam int unsigned KW    = $clog2(NBITS);

    fsm_e          state;
    logic [3:0]    stg;
    logic [KW-1:0] kidx;
    logic [M-1:0]  kq;
    logic          mask_q;
    logic [15:0]   rcnt;
    logic [3:0]    nstg;
    logic          kbit, init, launch, wb, rnd_cap, commit, mul_done;

    assign nstg    = stage_count(mask_q);
    assign kbit    = kq[kidx];
    assign init    = (state == ST_IDLE) && start;
    assign launch  = (state == ST_LAUNCH);
    assign wb      = (state == ST_WAIT) && mul_done;
    assign rnd_cap = (state == ST_RBEGIN) && mask_q && rnd_valid;
    assign commit  = (state == ST_COMMIT);

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            stg    <= '0;
            kidx   <= '0;
            kq     <= '0;
            mask_q <= 1'b0;
            rcnt   <= '0;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    kq     <= scalar;
                    mask_q <= mask_en;
                    kidx   <= KW'(NBITS - 1);
                    state  <= ST_RBEGIN;
                end
                ST_RBEGIN: if (!mask_q || rnd_valid) begin
                    stg   <= '0;
                    rcnt  <= 16'd1;
                    state <= ST_LAUNCH;
                end
                ST_LAUNCH: begin
                    rcnt  <= rcnt + 1'b1;
                    state <= ST_WAIT;
                end
                ST_WAIT: begin
                    rcnt <= rcnt + 1'b1;
                    if (mul_done) begin
                        if (stg == nstg - 1'b1) begin
                            state <= ST_COMMIT;
                        end else begin
                            stg   <= stg + 1'b1;
                            state <= ST_LAUNCH;
                        end
                    end
                end
                ST_COMMIT: begin
                    if (kidx == '0) begin
                        state <= ST_DONE;
                    end else begin
                        kidx  <= kidx - 1'b1;
                        state <= ST_RBEGIN;
                    end
                end
                ST_DONE:  state <= ST_IDLE;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    ladder_datapath #(.M(M), .POLY_LOW(POLY_LOW)) dp_i (
        .clk       (clk),
        .rst       (rst),
        .init      (init),
        .base_x    (base_x),
        .curve_b   (curve_b),
        .launch    (launch),
        .stg       (stg),
        .wb        (wb),
        .rnd_cap   (rnd_cap),
        .rnd_value (rnd_value),
        .commit    (commit),
        .kbit      (kbit),
        .mul_done  (mul_done),
        .r0_x      (res_x),
        .r0_z      (res_z)
    );

    assign rnd_ready = (state == ST_RBEGIN) && mask_q;
    assign busy      = (state != ST_IDLE);
    assign done      = (state == ST_DONE);

    p_done_pulse_r2: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    p_round_len_r8: assert property (@(posedge clk) disable iff (rst)
        (state == ST_COMMIT) |-> (rcnt == 16'(1 + int'(nstg) * (M + 2))));
    p_rnd_masked_r6: assert property (@(posedge clk) disable iff (rst)
        rnd_ready |-> mask_q);
    p_busy_start_ignored_r10: assert property (@(posedge clk) disable iff (rst)
        (state != ST_IDLE) |=> $stable(kq) && $stable(mask_q));

endmodule

// File: tb/ladder_round_engine_tb.sv
`timescale 1ns/1ps
module ladder_round_engine_tb_top;
    localparam int unsigned M = 8;
    localparam logic [M-1:0] POLY = 8'h1B;
    localparam int LAT_PROT  = M * (13 * (M + 2) + 2) + 1;
    localparam int LAT_PLAIN = M * (11 * (M + 2) + 2) + 1;
    localparam logic [M-1:0] BX = 8'h57;
    localparam logic [M-1:0] BB = 8'h3C;

    logic clk = 1'b0;
    logic rst, start, mask_en, rnd_valid, rnd_ready, busy, done;
    logic [M-1:0] scalar, base_x, curve_b, rnd_value, res_x, res_z;
    int n_checks = 0, n_errors = 0, hs = 0, rnd_mode = 0;

    always #4 clk = ~clk;

    ladder_round_engine #(.M(M), .POLY_LOW(POLY)) dut_i (
        .clk(clk), .rst(rst), .start(start), .mask_en(mask_en), .scalar(scalar),
        .base_x(base_x), .curve_b(curve_b), .rnd_valid(rnd_valid),
        .rnd_value(rnd_value), .rnd_ready(rnd_ready), .busy(busy), .done(done),
        .res_x(res_x), .res_z(res_z)
    );

    function automatic logic [M-1:0] gmul(input logic [M-1:0] a, input logic [M-1:0] b);
        logic [M-1:0] r = '0, aa = a;
        for (int i = 0; i < M; i++) begin
            if (b[i]) r ^= aa;
            aa = aa[M-1] ? ((aa << 1) ^ POLY) : (aa << 1);
        end
        return r;
    endfunction

    function automatic logic [M-1:0] ginv(input logic [M-1:0] a);
        for (int v = 1; v < (1 << M); v++)
            if (gmul(a, M'(v)) == M'(1)) return M'(v);
        return '0;
    endfunction

    function automatic logic [M-1:0] rgen(input int mode, input int i);
        if (mode == 1) return '0;
        if (mode == 2) return M'(1);
        return M'(i * 29 + 7) ^ M'(i << 3);
    endfunction

    // Reference ladder built from the requirement formulas
    function automatic logic [2*M-1:0] ref_ladder(input logic [M-1:0] k, input logic prot,
                                                  input int mode);
        logic [M-1:0] x0 = M'(1), z0 = '0, x1 = BX, z1 = M'(1);
        logic [M-1:0] p1, p2, za, xa, xd, zd, xn, zn, r, t;
        for (int i = M - 1; i >= 0; i--) begin
            r  = prot ? rgen(mode, M - 1 - i) : M'(1);
            if (r == '0) r = M'(1);
            p1 = gmul(x0, z1);
            p2 = gmul(x1, z0);
            za = gmul(p1 ^ p2, p1 ^ p2);
            xa = gmul(BX, za) ^ gmul(p1, p2);
            xd = k[i] ? x1 : x0;
            zd = k[i] ? z1 : z0;
            t  = gmul(xd, xd);
            zn = gmul(t, gmul(zd, zd));
            xn = gmul(t, t) ^ gmul(BB, gmul(gmul(zd, zd), gmul(zd, zd)));
            xa = gmul(xa, r); za = gmul(za, r); xn = gmul(xn, r); zn = gmul(zn, r);
            if (k[i]) begin x0 = xa; z0 = za; x1 = xn; z1 = zn; end
            else      begin x1 = xa; z1 = za; x0 = xn; z0 = zn; end
        end
        return {x0, z0};
    endfunction

    function automatic logic [M-1:0] affine(input logic [M-1:0] x, input logic [M-1:0] z);
        return gmul(x, ginv(z));
    endfunction

    always @(negedge clk) begin
        if (rnd_ready && rnd_valid) begin
            rnd_value = rgen(rnd_mode, hs);
            hs++;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic run_mult(input logic [M-1:0] k, input logic prot, input int mode,
                            output logic [M-1:0] ox, output logic [M-1:0] oz,
                            output int lat, output int nhs);
        @(negedge clk);
        rnd_mode = mode; hs = 0;
        scalar = k; mask_en = prot; start = 1'b1;
        @(posedge clk); #2;
        start = 1'b0; lat = 1;
        while (!done && lat < 5000) begin @(posedge clk); #2; lat++; end
        ox = res_x; oz = res_z; nhs = hs;
        @(posedge clk); #2;
        chk(!done, "R2", "done pulse width", 32'(done), 0);
    endtask

    task automatic t_reset();
        rst = 1'b1; start = 1'b0; mask_en = 1'b0; scalar = '0;
        base_x = BX; curve_b = BB; rnd_valid = 1'b1; rnd_value = '0;
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
        @(posedge clk); #2;
        chk(!busy && !done && !rnd_ready, "R1", "idle flags",
            {busy, done, rnd_ready}, 0);
        chk(res_x == '0 && res_z == '0, "R1", "result regs", {res_x, res_z}, 0);
    endtask

    task automatic t_low_scalars();
        logic [M-1:0] x, z, e;
        int lat, n;
        run_mult(8'd0, 1'b1, 0, x, z, lat, n);
        chk(z == '0, "R3", "k=0 gives Z=0", z, 0);
        run_mult(8'd1, 1'b0, 0, x, z, lat, n);
        chk(affine(x, z) == BX, "R3", "k=1 plain affine", affine(x, z), BX);
        run_mult(8'd1, 1'b1, 0, x, z, lat, n);
        chk(affine(x, z) == BX, "R3", "k=1 protected affine", affine(x, z), BX);
        e = gmul(BX, BX) ^ gmul(BB, ginv(gmul(BX, BX)));
        run_mult(8'd2, 1'b1, 0, x, z, lat, n);
        chk(affine(x, z) == e, "R3", "k=2 doubling affine", affine(x, z), e);
    endtask

    task automatic t_patterns();
        logic [7:0] ks [4] = '{8'hA5, 8'h80, 8'hFF, 8'h3C};
        logic [M-1:0] px, pz, qx, qz;
        logic [2*M-1:0] ref_p, ref_q;
        int lat, n;
        foreach (ks[j]) begin
            ref_p = ref_ladder(ks[j], 1'b0, 0);
            run_mult(ks[j], 1'b0, 0, px, pz, lat, n);
            chk({px, pz} == ref_p, "R4", "plain projective (R2)", {px, pz}, ref_p);
            chk(lat == LAT_PLAIN, "R8", "plain latency", lat, LAT_PLAIN);
            chk(n == 0, "R6", "no handshake when plain", n, 0);
            ref_q = ref_ladder(ks[j], 1'b1, 0);
            run_mult(ks[j], 1'b1, 0, qx, qz, lat, n);
            chk({qx, qz} == ref_q, "R11", "protected projective", {qx, qz}, ref_q);
            chk(affine(qx, qz) == affine(px, pz), "R5", "mode affine match",
                affine(qx, qz), affine(px, pz));
            chk(lat == LAT_PROT, "R8", "protected latency", lat, LAT_PROT);
            chk(n == M, "R6", "one handshake per round", n, M);
        end
    endtask

    task automatic t_zero_rnd();
        logic [M-1:0] x, z;
        logic [2*M-1:0] ref_p;
        int lat, n;
        ref_p = ref_ladder(8'hC3, 1'b0, 0);
        run_mult(8'hC3, 1'b1, 1, x, z, lat, n);
        chk({x, z} == ref_p, "R7", "zero randoms act as one", {x, z}, ref_p);
        chk(z != '0, "R7", "point not collapsed", z, 1);
    endtask

    task automatic t_busy_start();
        logic [2*M-1:0] ref_p;
        int lat;
        ref_p = ref_ladder(8'h6B, 1'b1, 0);
        @(negedge clk);
        rnd_mode = 0; hs = 0; scalar = 8'h6B; mask_en = 1'b1; start = 1'b1;
        @(posedge clk); #2;
        start = 1'b0; lat = 1;
        repeat (40) begin @(posedge clk); #2; lat++; end
        scalar = 8'h11; mask_en = 1'b0; start = 1'b1;
        @(posedge clk); #2;
        start = 1'b0; lat++;
        while (!done && lat < 5000) begin @(posedge clk); #2; lat++; end
        chk({res_x, res_z} == ref_p, "R10", "result unaffected", {res_x, res_z}, ref_p);
        chk(lat == LAT_PROT, "R10", "latency unaffected", lat, LAT_PROT);
        @(posedge clk); #2;
    endtask

    initial begin
        #(8 * 190000);
        n_errors++;
        $display("FAIL watchdog all-requirements actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        t_reset();
        t_low_scalars();
        t_patterns();
        t_zero_rnd();
        t_busy_start();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule